// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs memory and I/O read and write cycles on a bus that shares its lines between address and data. A client hands over one transfer at a time through a valid/ready request port. Each request carries the cycle kind, a 16-bit segment, a 16-bit offset, write data and a width flag. The sequencer forms a 20-bit physical address, which is the segment times sixteen plus the offset, wrapped modulo 2^20. It then steps through four clock states: an address phase, a strobe phase, a data phase and a closing phase. It drives the address latch strobe, the read and write strobes, the space select, the direction select and the transceiver enable. The data phase is stretched by wait states for as long as the slave holds its ready line low.

Back-pressure rule: `req_ready` is high only while the sequencer is idle. A request moves only in a cycle where `req_valid` and `req_ready` are both high. All request fields are captured in that cycle, so the client may change them afterwards. The result has no back-pressure: `rsp_valid` is a one-cycle pulse, and `rsp_rdata` is valid in that same cycle.

The parameter `BUS_W` chooses a 16-bit or an 8-bit external data path. On the 8-bit path, a 16-bit transfer becomes two complete bus cycles: the low byte first, then the high byte.

Top module: `bus_cycle_seq`

## Requirements
- R1: `req_ready` is 1 exactly while idle. An accepted request puts the sequencer in the address phase in the next cycle. Request fields that change after acceptance have no effect on the cycle.
- R2: In the address phase, `ale`=1, `ad_oe`=1 and `ad_o` carries the physical address. `ale` is high for exactly that one cycle of each bus cycle.
- R3: Kinds are encoded as 00 memory read, 01 memory write, 10 I/O read and 11 I/O write. From the strobe phase through the data phase and any wait states, `rd_stb` is high for kinds 00 and 10, and `wr_stb` is high for kinds 01 and 11. Both strobes are low in the address and closing phases, and the two are never high together.
- R4: From the address phase through the closing phase, `mem_sel` equals the inverse of kind bit 1 and `dir_tx` equals kind bit 0. Both hold steady for the whole cycle.
- R5: `den` is high from the strobe phase to the last data or wait cycle, and low in the address phase, the closing phase and idle.
- R6: In a write, `ad_oe`=1 from the strobe phase through the closing phase, and `ad_o` carries the data lane with all higher bits 0. In a read, `ad_oe`=0 after the address phase.
- R7: `bus_ready` is sampled only at the end of the data phase and of each wait state. A low sample adds one wait state with the strobes held. With `bus_ready` high, the closing phase is the fourth cycle of the bus cycle.
- R8: `rsp_valid` is a one-cycle pulse in the closing phase of the final bus cycle of a transfer. For reads, `rsp_rdata` then holds the `ad_i` value taken in the cycle where `bus_ready` was sampled high.
- R9: With `BUS_W`=8 and width flag 1, two bus cycles run. The first carries data bits 7:0 at the base address. The second carries bits 15:8 at base+1, wrapped modulo 2^20. Only one `rsp_valid` pulse is given, after the second cycle.
- R10: With width flag 0, one bus cycle runs on data lane bits 7:0. A write drives `req_wdata[7:0]` with the upper lane bits 0. A read returns `ad_i[7:0]` zero-extended to 16 bits.
- R11: While idle, `ale`, `rd_stb`, `wr_stb`, `den`, `mem_sel`, `dir_tx`, `ad_oe` and `ad_o` are all 0.
- R12: The physical address is (segment shifted left by 4) + offset modulo 2^20. For example, segment FFFF with offset FFFF gives 0FFEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | Cycle kind (bit 1: I/O space, bit 0: write) |
| req_seg | input | SEG_W | Segment value |
| req_off | input | OFF_W | Offset value |
| req_wdata | input | DATA_W | Write data |
| req_wide | input | 1 | 1: 16-bit transfer, 0: byte transfer |
| rsp_valid | output | 1 | Transfer done pulse |
| rsp_rdata | output | DATA_W | Read data |
| ale | output | 1 | Address latch strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| mem_sel | output | 1 | 1: memory space, 0: I/O space |
| dir_tx | output | 1 | 1: sequencer drives data, 0: receives |
| den | output | 1 | Data transceiver enable |
| ad_o | output | SEG_W+4 | Multiplexed address/data out |
| ad_oe | output | 1 | Output enable for ad_o (0 = tristate) |
| ad_i | input | BUS_W | Data in from the bus |
| bus_ready | input | 1 | Slave ready |

## Verification
Two things can land in the same cycle. One is the wait-state exit: `bus_ready` rises while the read data is captured in that very cycle. The other is the closing phase, where the done pulse fires while a new request is already being offered. The bench raises `bus_ready` early in the address phase, drives garbage on `ad_i` during every wait, and keeps a garbage request valid for the whole cycle. A correct design takes the data only on the cycle where ready is high. It gives one pulse and starts nothing new before it returns to idle. Both bus widths run a seeded random mix of kinds, widths and wait counts, plus directed cases at the wrap of the 20-bit address.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  localparam int BYTE_W      = 8;
  localparam int KIND_WR_BIT = 0;
  localparam int KIND_IO_BIT = 1;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } bcs_state_e;
endpackage

// File: rtl/bcs_tstate_fsm.sv
module bcs_tstate_fsm
  import bcs_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       wide,
  input  logic       bus_ready,
  output bcs_state_e state,
  output logic       beat,
  output logic       last_beat,
  output logic       capture,
  output logic       done
);
  bcs_state_e state_q, state_d;
  logic       beat_q, beat_d;

  assign last_beat = !(SPLIT && wide && !beat_q);
  assign capture   = ((state_q == ST_T3) || (state_q == ST_TW)) && bus_ready;
  assign done      = (state_q == ST_T4) && last_beat;
  assign state     = state_q;
  assign beat      = beat_q;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_T1;
        beat_d  = 1'b0;
      end
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = bus_ready ? ST_T4 : ST_TW;
      ST_T4: begin
        if (last_beat) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_T1;
          beat_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assert_accept_to_t1_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == ST_T1));

  assert_wait_on_low_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((state_q == ST_T3) || (state_q == ST_TW)) && !bus_ready) |=> (state_q == ST_TW));

  assert_done_then_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state_q == ST_IDLE));

  assert_second_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_T4) && !last_beat) |=> ((state_q == ST_T1) && beat_q));
endmodule

// File: rtl/bcs_phys_addr.sv
module bcs_phys_addr #(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = SEG_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  input  logic              beat,
  output logic [ADDR_W-1:0] phys
);
  localparam int SHIFT = ADDR_W - SEG_W;

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] seg_ext;
  logic [ADDR_W-1:0] off_ext;

  assign seg_ext = {seg, {SHIFT{1'b0}}};
  assign off_ext = {{(ADDR_W-OFF_W){1'b0}}, off};

  always_ff @(posedge clk) begin
    if (!rst_n)    base_q <= '0;
    else if (load) base_q <= seg_ext + off_ext;
  end

  assign phys = base_q + {{(ADDR_W-1){1'b0}}, beat};

  assert_next_byte_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $rose(beat)) |-> (phys == $past(phys) + 1'b1));
endmodule

// File: rtl/bcs_lane_mux.sv
module bcs_lane_mux
  import bcs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wide,
  input  logic              beat,
  input  logic              capture,
  input  logic [BUS_W-1:0]  ad_i,
  output logic [BUS_W-1:0]  wr_lane,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    wdata_q <= '0;
    else if (load) wdata_q <= wdata;
  end

  generate
    if (BUS_W < DATA_W) begin : g_narrow
      assign wr_lane = (beat && wide) ? wdata_q[DATA_W-1 -: BUS_W] : wdata_q[BUS_W-1:0];
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rdata_q <= '0;
        end else if (capture) begin
          if (beat && wide) rdata_q[DATA_W-1 -: BUS_W] <= ad_i;
          else              rdata_q <= {{(DATA_W-BUS_W){1'b0}}, ad_i};
        end
      end
    end else begin : g_full
      assign wr_lane = wide ? wdata_q : {{(DATA_W-BYTE_W){1'b0}}, wdata_q[BYTE_W-1:0]};
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rdata_q <= '0;
        end else if (capture && !beat) begin
          rdata_q <= wide ? ad_i : {{(DATA_W-BYTE_W){1'b0}}, ad_i[BYTE_W-1:0]};
        end
      end
    end
  endgenerate

  assign rdata = rdata_q;

  assert_byte_zero_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !wide) |=> (rdata_q[DATA_W-1:BYTE_W] == '0));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bcs_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [1:0]          req_kind,
  input  logic [SEG_W-1:0]    req_seg,
  input  logic [OFF_W-1:0]    req_off,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic                req_wide,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                ale,
  output logic                rd_stb,
  output logic                wr_stb,
  output logic                mem_sel,
  output logic                dir_tx,
  output logic                den,
  output logic [SEG_W+3:0]    ad_o,
  output logic                ad_oe,
  input  logic [BUS_W-1:0]    ad_i,
  input  logic                bus_ready
);
  localparam int  ADDR_W = SEG_W + 4;
  localparam bit  SPLIT  = (BUS_W < DATA_W);

  bcs_state_e        state;
  logic              beat, last_beat, capture, done, start;
  logic [1:0]        kind_q;
  logic              wide_q;
  logic [ADDR_W-1:0] phys;
  logic [BUS_W-1:0]  wr_lane;
  logic              is_wr, is_io, busy, xfer, data_phase;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= '0;
      wide_q <= 1'b0;
    end else if (start) begin
      kind_q <= req_kind;
      wide_q <= req_wide;
    end
  end

  bcs_tstate_fsm #(.SPLIT(SPLIT)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wide      (wide_q),
    .bus_ready (bus_ready),
    .state     (state),
    .beat      (beat),
    .last_beat (last_beat),
    .capture   (capture),
    .done      (done)
  );

  bcs_phys_addr #(.SEG_W(SEG_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .seg   (req_seg),
    .off   (req_off),
    .beat  (beat),
    .phys  (phys)
  );

  bcs_lane_mux #(.DATA_W(DATA_W), .BUS_W(BUS_W)) u_lanes (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .wdata   (req_wdata),
    .wide    (wide_q),
    .beat    (beat),
    .capture (capture),
    .ad_i    (ad_i),
    .wr_lane (wr_lane),
    .rdata   (rsp_rdata)
  );

  assign is_wr      = kind_q[KIND_WR_BIT];
  assign is_io      = kind_q[KIND_IO_BIT];
  assign busy       = (state != ST_IDLE);
  assign xfer       = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign data_phase = xfer || (state == ST_T4);

  assign ale       = (state == ST_T1);
  assign rd_stb    = xfer && !is_wr;
  assign wr_stb    = xfer && is_wr;
  assign den       = xfer;
  assign mem_sel   = busy && !is_io;
  assign dir_tx    = busy && is_wr;
  assign ad_oe     = ale || (is_wr && data_phase);
  assign ad_o      = ale ? phys :
                     (is_wr && data_phase) ? {{(ADDR_W-BUS_W){1'b0}}, wr_lane} : '0;
  assign rsp_valid = done;

  assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_stb && wr_stb));

  assert_space_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> ($stable(mem_sel) && $stable(dir_tx)));

  assert_den_with_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    den |-> (rd_stb || wr_stb));

  assert_read_lanes_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !ad_oe);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(ale || rd_stb || wr_stb || den || ad_oe || mem_sel || dir_tx));
endmodule

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  logic        sel8;
  logic        req_valid;
  logic [1:0]  req_kind;
  logic [15:0] req_seg, req_off, req_wdata;
  logic        req_wide;
  logic        bus_ready;
  logic [15:0] ad_i_a;
  logic [7:0]  ad_i_b;

  logic        rdy_a, rsv_a, ale_a, rd_a, wr_a, ms_a, dt_a, den_a, oe_a;
  logic [15:0] rdat_a;
  logic [19:0] ado_a;
  logic        rdy_b, rsv_b, ale_b, rd_b, wr_b, ms_b, dt_b, den_b, oe_b;
  logic [15:0] rdat_b;
  logic [19:0] ado_b;

  bus_cycle_seq #(.BUS_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && !sel8), .req_ready(rdy_a),
    .req_kind(req_kind), .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
    .req_wide(req_wide), .rsp_valid(rsv_a), .rsp_rdata(rdat_a), .ale(ale_a),
    .rd_stb(rd_a), .wr_stb(wr_a), .mem_sel(ms_a), .dir_tx(dt_a), .den(den_a),
    .ad_o(ado_a), .ad_oe(oe_a), .ad_i(ad_i_a), .bus_ready(bus_ready));

  bus_cycle_seq #(.BUS_W(8)) dut8 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid && sel8), .req_ready(rdy_b),
    .req_kind(req_kind), .req_seg(req_seg), .req_off(req_off), .req_wdata(req_wdata),
    .req_wide(req_wide), .rsp_valid(rsv_b), .rsp_rdata(rdat_b), .ale(ale_b),
    .rd_stb(rd_b), .wr_stb(wr_b), .mem_sel(ms_b), .dir_tx(dt_b), .den(den_b),
    .ad_o(ado_b), .ad_oe(oe_b), .ad_i(ad_i_b), .bus_ready(bus_ready));

  wire        o_rdy = sel8 ? rdy_b : rdy_a;
  wire        o_rsv = sel8 ? rsv_b : rsv_a;
  wire [15:0] o_rdat = sel8 ? rdat_b : rdat_a;
  wire        o_ale = sel8 ? ale_b : ale_a;
  wire        o_rd  = sel8 ? rd_b : rd_a;
  wire        o_wr  = sel8 ? wr_b : wr_a;
  wire        o_ms  = sel8 ? ms_b : ms_a;
  wire        o_dt  = sel8 ? dt_b : dt_a;
  wire        o_den = sel8 ? den_b : den_a;
  wire        o_oe  = sel8 ? oe_b : oe_a;
  wire [19:0] o_ado = sel8 ? ado_b : ado_a;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [19:0] phys_of(input logic [15:0] s, input logic [15:0] o);
    return {s, 4'h0} + {4'h0, o};
  endfunction

  function automatic logic [15:0] lane_of(input bit s8, input bit wide, input int b, input logic [15:0] wd);
    if (s8) return {8'h00, (b == 1) ? wd[15:8] : wd[7:0]};
    return wide ? wd : {8'h00, wd[7:0]};
  endfunction

  function automatic logic [15:0] rexp_of(input bit wide, input logic [15:0] sd);
    return wide ? sd : {8'h00, sd[7:0]};
  endfunction

  task automatic drive_in(input bit s8, input bit wide, input int b, input logic [15:0] sd, input bit good);
    logic [15:0] junk;
    junk = 16'($urandom);
    if (!good) begin
      ad_i_a = junk;
      ad_i_b = junk[7:0];
    end else if (s8) begin
      ad_i_b = (b == 1) ? sd[15:8] : sd[7:0];
    end else begin
      ad_i_a = wide ? sd : {junk[15:8], sd[7:0]};
    end
  endtask

  task automatic check_idle(input string tag);
    chk(o_rdy == 1'b1, {tag, " R1 ready in idle"}, o_rdy, 1);
    chk({o_ale, o_rd, o_wr, o_den, o_ms, o_dt, o_oe} == 7'b0, {tag, " R11 idle strobes"},
        {o_ale, o_rd, o_wr, o_den, o_ms, o_dt, o_oe}, 0);
    chk(o_ado == 20'h0, {tag, " R11 idle ad_o"}, o_ado, 0);
    chk(o_rsv == 1'b0, {tag, " R8 no pulse in idle"}, o_rsv, 0);
  endtask

  task automatic run_txn(input bit s8, input logic [1:0] kind, input logic [15:0] seg,
                         input logic [15:0] off, input logic [15:0] wd, input bit wide,
                         input int waits, input logic [15:0] sd);
    int   nbeats;
    bit   wr;
    logic [19:0] ea;
    nbeats = (s8 && wide) ? 2 : 1;
    wr = kind[0];
    @(negedge clk);
    sel8 = s8;
    #0;
    check_idle("pre");
    req_kind = kind; req_seg = seg; req_off = off; req_wdata = wd; req_wide = wide;
    req_valid = 1'b1;
    for (int b = 0; b < nbeats; b++) begin
      @(negedge clk);
      if (b == 0) begin
        req_kind = 2'($urandom); req_seg = 16'($urandom); req_off = 16'($urandom);
        req_wdata = 16'($urandom); req_wide = 1'($urandom);
      end
      bus_ready = 1'b1;
      ea = phys_of(seg, off) + 20'(b);
      chk(o_ale == 1'b1, "R2 ale in T1", o_ale, 1);
      chk(o_oe == 1'b1, "R2 oe in T1", o_oe, 1);
      chk(o_ado == ea, (b == 1) ? "R9 second byte address" : "R12 R2 address", o_ado, ea);
      chk(o_rdy == 1'b0, "R1 busy not ready", o_rdy, 0);
      chk({o_rd, o_wr} == 2'b00, "R3 no strobe in T1", {o_rd, o_wr}, 0);
      chk(o_den == 1'b0, "R5 den low in T1", o_den, 0);
      chk(o_ms == !kind[1], "R4 mem_sel", o_ms, !kind[1]);
      chk(o_dt == kind[0], "R4 dir_tx", o_dt, kind[0]);
      @(negedge clk);
      chk(o_ale == 1'b0, "R2 ale one cycle", o_ale, 0);
      chk({o_rd, o_wr} == {!wr, wr}, "R3 strobe in T2", {o_rd, o_wr}, {!wr, wr});
      chk(o_den == 1'b1, "R5 den in T2", o_den, 1);
      chk(o_oe == wr, "R6 oe in T2", o_oe, wr);
      if (wr) chk(o_ado == {4'h0, lane_of(s8, wide, b, wd)}, "R6 R10 write lane",
                  o_ado, {4'h0, lane_of(s8, wide, b, wd)});
      @(negedge clk);
      chk({o_rd, o_wr} == {!wr, wr}, "R3 strobe in T3", {o_rd, o_wr}, {!wr, wr});
      chk(o_den == 1'b1, "R5 den in T3", o_den, 1);
      bus_ready = (waits == 0);
      drive_in(s8, wide, b, sd, waits == 0);
      for (int w = waits; w > 0; w--) begin
        @(negedge clk);
        chk({o_rd, o_wr} == {!wr, wr}, "R7 strobe held in wait", {o_rd, o_wr}, {!wr, wr});
        chk(o_den == 1'b1, "R5 den in wait", o_den, 1);
        chk(o_rsv == 1'b0, "R7 no done in wait", o_rsv, 0);
        if (wr) chk(o_ado == {4'h0, lane_of(s8, wide, b, wd)}, "R6 write lane held",
                    o_ado, {4'h0, lane_of(s8, wide, b, wd)});
        bus_ready = (w == 1);
        drive_in(s8, wide, b, sd, w == 1);
      end
      @(negedge clk);
      bus_ready = 1'b0;
      drive_in(s8, wide, b, sd, 1'b0);
      chk({o_rd, o_wr} == 2'b00, "R3 strobes off in T4", {o_rd, o_wr}, 0);
      chk(o_den == 1'b0, "R5 den low in T4", o_den, 0);
      chk(o_ale == 1'b0, "R7 T4 reached", o_ale, 0);
      chk(o_ms == !kind[1] && o_dt == kind[0], "R4 held in T4", {o_ms, o_dt}, {!kind[1], kind[0]});
      chk(o_oe == wr, "R6 oe in T4", o_oe, wr);
      chk(o_rsv == (b == nbeats - 1), (nbeats == 2) ? "R9 single done" : "R8 done in T4",
          o_rsv, (b == nbeats - 1));
      if (b == nbeats - 1) begin
        if (!wr) chk(o_rdat == rexp_of(wide, sd), wide ? "R8 read data" : "R10 byte read",
                     o_rdat, rexp_of(wide, sd));
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    check_idle("post");
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel8 = 1'b0; req_valid = 1'b0; req_kind = '0; req_seg = '0;
    req_off = '0; req_wdata = '0; req_wide = 1'b0; bus_ready = 1'b0;
    ad_i_a = '0; ad_i_b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("reset");
    sel8 = 1'b1;
    #0;
    check_idle("reset8");

    run_txn(1'b0, 2'b00, 16'hFFFF, 16'hFFFF, 16'h0, 1'b1, 0, 16'hBEEF);
    run_txn(1'b0, 2'b01, 16'h1000, 16'h0100, 16'hA55A, 1'b1, 0, 16'h0);
    run_txn(1'b0, 2'b10, 16'h0000, 16'h03F8, 16'h0, 1'b0, 3, 16'h7E81);
    run_txn(1'b0, 2'b11, 16'h0000, 16'h0060, 16'hC3D4, 1'b0, 1, 16'h0);
    run_txn(1'b1, 2'b01, 16'hF000, 16'hFFFF, 16'h1234, 1'b1, 2, 16'h0);
    run_txn(1'b1, 2'b00, 16'hF000, 16'hFFFF, 16'h0, 1'b1, 0, 16'hCAFE);
    run_txn(1'b1, 2'b10, 16'h2000, 16'h0500, 16'h0, 1'b0, 6, 16'h9A5C);
    run_txn(1'b1, 2'b00, 16'h1234, 16'h5678, 16'h0, 1'b1, 5, 16'h0FF0);

    for (int i = 0; i < 80; i++) begin
      run_txn(1'($urandom), 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
              1'($urandom), int'($urandom % 4), 16'($urandom));
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule